// File: doc/BRIEF.md
# Host Request and Reply Queue Ports

This block gives a host processor a small set of 32-bit registers for handing work to an internal processing engine and for collecting the results. The host posts a request by writing the address of a request frame to the request port. That address goes into a request FIFO, which the engine drains through a valid/ready pair. When the engine finishes a request, it offers a completion. A successful completion carries the request's context value. A failed completion needs a reply frame that the host has donated earlier.

The reply port serves two purposes. A host read pops the oldest completion, and reads the all-ones value when nothing is waiting. A host write returns a free reply-frame address to a free-frame FIFO. A failed completion takes one free frame and reports it to the host as an address reply. A pending-reply status bit drives a maskable interrupt, and the host acknowledges it by writing the status register.

Top module: `qport_top`

## Requirements
- R1: A host write to offset 0x40 pushes the written frame address into an 8-entry request FIFO. The engine sees the addresses on `req_frame` in write order while `req_valid` is high, and pops one per cycle in which `req_valid` and `req_ready` are both high.
- R2: A write to offset 0x40 while the request FIFO holds 8 entries is dropped. It sets `req_overflow`, which then stays high until reset.
- R3: A completion accepted with `cpl_fault` low places the value {1'b0, cpl_context[30:0]} in the reply FIFO. Host reads of offset 0x44 return the replies in acceptance order and pop one each.
- R4: A read of offset 0x44 with the reply FIFO empty returns 32'hFFFF_FFFF and leaves the FIFO unchanged.
- R5: A completion with `cpl_fault` high takes the oldest free frame and queues the reply {1'b1, frame[31:1]}. While no free frame is held, `cpl_ready` stays low and the completion waits.
- R6: A host write to offset 0x44 stores bits 31:1 of the written address in an 8-entry free-frame FIFO.
- R7: Status bit 3 (read at offset 0x30) becomes 1 one cycle after the reply FIFO turns non-empty. Any write to offset 0x30 clears it, and it returns one cycle later if replies remain.
- R8: The mask register at offset 0x34 keeps only bits 0, 3, 8 and 9 of a write; all other bits read 0. Its reset value is 0.
- R9: `irq` is high exactly when status bit 3 is 1 and mask bit 3 is 0.
- R10: The reply FIFO holds 8 entries. With 8 queued, `cpl_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops on reply port) |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from address |
| req_valid | output | 1 | Request FIFO holds a frame address |
| req_frame | output | 32 | Oldest request frame address |
| req_ready | input | 1 | Engine takes the oldest request |
| cpl_valid | input | 1 | Engine offers a completion |
| cpl_fault | input | 1 | Completion is a failure needing a reply frame |
| cpl_context | input | 31 | Context value of a successful completion |
| cpl_ready | output | 1 | Completion accepted this cycle |
| irq | output | 1 | Reply interrupt after masking |
| req_overflow | output | 1 | Sticky request-drop flag |

## Verification
Successful completions are driven with random context values and mixed with random reply reads, some of them on an empty queue. This separates correct ordering and empty-marker handling from stale or repeated pops. Directed cases cover the following:
- filling and overflowing the request FIFO, which separates dropping from overwriting;
- a failed completion arriving before any free frame exists, which shows the stall and the frame-to-reply encoding;
- a full reply FIFO;
- acknowledge-with-data-pending and mask write patterns, which tell the re-assert and masking rules apart from a plain level copy.

// File: rtl/qport_pkg.sv
// Shared offsets and constants for the queue port block.
package qport_pkg;
    localparam logic [7:0] OFS_STATUS = 8'h30;
    localparam logic [7:0] OFS_MASK   = 8'h34;
    localparam logic [7:0] OFS_REQ    = 8'h40;
    localparam logic [7:0] OFS_REPLY  = 8'h44;
    localparam logic [31:0] MASK_WRITABLE = 32'h0000_0309;
    localparam logic [31:0] EMPTY_MARK    = 32'hFFFF_FFFF;
    localparam int STS_REPLY_BIT = 3;
endpackage

// File: rtl/qport_fifo.sv
// Generic synchronous FIFO.
// Assumes: a push while full is dropped, and a pop while empty is ignored.
// Head data is shown combinationally.
module qport_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Store data on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/qport_irq.sv
// Reply status bit, mask register and interrupt output.
// Assumes: ack is any host write to the status offset. The status bit sets
// from the reply FIFO level with one cycle of delay.
module qport_irq
    import qport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ack,
    input  logic        mask_we,
    input  logic [31:0] mask_wdata,
    input  logic        reply_pending,
    output logic        sts_q,
    output logic [31:0] mask_q,
    output logic        irq
);
    // Pending-reply status: cleared by ack, otherwise set while replies wait.
    always_ff @(posedge clk) begin
        if (!rst_n)   sts_q <= 1'b0;
        else if (ack) sts_q <= 1'b0;
        else          sts_q <= sts_q | reply_pending;
    end

    // Mask register keeps only its writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata & MASK_WRITABLE;
    end

    // Interrupt is the status bit gated by its mask bit.
    always_comb irq = sts_q & ~mask_q[STS_REPLY_BIT];
endmodule

// File: rtl/qport_top.sv
// Host-facing request and reply queue ports.
// Assumes: single-cycle host strobes and a read data path decoded from the
// address in the same cycle. A read of the reply port pops at the clock edge.
module qport_top
    import qport_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        req_valid,
    output logic [31:0] req_frame,
    input  logic        req_ready,
    input  logic        cpl_valid,
    input  logic        cpl_fault,
    input  logic [30:0] cpl_context,
    output logic        cpl_ready,
    output logic        irq,
    output logic        req_overflow
);
    logic        req_push, req_empty, req_full;
    logic        free_push, free_pop, free_empty, free_full;
    logic [30:0] free_head;
    logic        reply_push, reply_pop, reply_empty, reply_full;
    logic [31:0] reply_din, reply_head;
    logic        sts_q;
    logic [31:0] mask_q;

    // Host write decode for the two queue ports.
    always_comb begin
        req_push  = host_wr && (host_addr == OFS_REQ);
        free_push = host_wr && (host_addr == OFS_REPLY) && !free_full;
        reply_pop = host_rd && (host_addr == OFS_REPLY);
    end

    qport_fifo #(.W(32), .DEPTH(DEPTH)) u_req (
        .clk(clk), .rst_n(rst_n), .push(req_push), .din(host_wdata),
        .pop(req_ready), .dout(req_frame), .empty(req_empty), .full(req_full)
    );
    assign req_valid = !req_empty;

    // Sticky flag for a request write dropped on a full FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n)                    req_overflow <= 1'b0;
        else if (req_push && req_full) req_overflow <= 1'b1;
    end

    qport_fifo #(.W(31), .DEPTH(DEPTH)) u_free (
        .clk(clk), .rst_n(rst_n), .push(free_push), .din(host_wdata[31:1]),
        .pop(free_pop), .dout(free_head), .empty(free_empty), .full(free_full)
    );

    // Completion acceptance: reply room, plus a free frame for a fault.
    always_comb begin
        cpl_ready  = cpl_valid && !reply_full && (!cpl_fault || !free_empty);
        reply_push = cpl_ready;
        free_pop   = cpl_ready && cpl_fault;
        reply_din  = cpl_fault ? {1'b1, free_head} : {1'b0, cpl_context};
    end

    qport_fifo #(.W(32), .DEPTH(DEPTH)) u_reply (
        .clk(clk), .rst_n(rst_n), .push(reply_push), .din(reply_din),
        .pop(reply_pop), .dout(reply_head), .empty(reply_empty), .full(reply_full)
    );

    qport_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .ack(host_wr && (host_addr == OFS_STATUS)),
        .mask_we(host_wr && (host_addr == OFS_MASK)),
        .mask_wdata(host_wdata),
        .reply_pending(!reply_empty),
        .sts_q(sts_q), .mask_q(mask_q), .irq(irq)
    );

    // Host read data multiplexer.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_STATUS: host_rdata[STS_REPLY_BIT] = sts_q;
            OFS_MASK:   host_rdata = mask_q;
            OFS_REPLY:  host_rdata = reply_empty ? EMPTY_MARK : reply_head;
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/qport_checks.sv
// Property checker for qport_top, attached through bind.
module qport_checks
    import qport_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_rd,
    input logic [7:0]  host_addr,
    input logic [31:0] host_rdata,
    input logic        cpl_valid,
    input logic        cpl_fault,
    input logic        cpl_ready,
    input logic        reply_empty,
    input logic        reply_full,
    input logic        free_empty,
    input logic        sts_q,
    input logic        irq,
    input logic        req_overflow
);
    // R4: empty reply port reads the all-ones marker
    a_r4_empty_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == OFS_REPLY && reply_empty) |-> host_rdata == EMPTY_MARK);
    // R5: a fault completion is only accepted with a free frame held
    a_r5_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_fault && cpl_ready) |-> !free_empty);
    // R2: overflow flag is sticky
    a_r2_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        req_overflow |=> req_overflow);
    // R7: a status write clears the pending bit
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_STATUS) |=> !sts_q);
    // R10: no completion accepted into a full reply FIFO
    a_r10_reply_room: assert property (@(posedge clk) disable iff (!rst_n)
        reply_full |-> !cpl_ready);
    // R9: interrupt needs the status bit
    a_r9_irq_needs_sts: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sts_q);
endmodule

bind qport_top qport_checks u_checks (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_rdata(host_rdata), .cpl_valid(cpl_valid),
    .cpl_fault(cpl_fault), .cpl_ready(cpl_ready), .reply_empty(reply_empty),
    .reply_full(reply_full), .free_empty(free_empty), .sts_q(sts_q),
    .irq(irq), .req_overflow(req_overflow)
);

// File: tb/test_qport_top.sv
module test_qport_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd;
    logic [7:0]  host_addr;
    logic [31:0] host_wdata, host_rdata;
    logic        req_valid, req_ready;
    logic [31:0] req_frame;
    logic        cpl_valid, cpl_fault, cpl_ready, irq, req_overflow;
    logic [30:0] cpl_context;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model_q[$];

    always #2 clk = ~clk;

    qport_top i_qport_top (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctx_reply(input logic [30:0] c);
        return {1'b0, c};
    endfunction

    function automatic logic [31:0] frame_reply(input logic [31:0] f);
        return {1'b1, f[31:1]};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic complete(input logic fault, input logic [30:0] c);
        @(negedge clk);
        cpl_valid = 1'b1; cpl_fault = fault; cpl_context = c;
        forever begin
            #1;
            if (cpl_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic take_req(output logic [31:0] f);
        @(negedge clk);
        #1 f = req_frame;
        req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    initial begin
        #400000;
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int unsigned seed;
        seed = 32'd1234;
        host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        req_ready = 0; cpl_valid = 0; cpl_fault = 0; cpl_context = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // Reset state
        check("R1 reset req_valid", {31'b0, req_valid}, 0);
        check("R2 reset overflow", {31'b0, req_overflow}, 0);
        check("R9 reset irq", {31'b0, irq}, 0);
        rd(8'h34, v); check("R8 mask reset", v, 0);

        // R4: empty read returns marker, twice, then a real reply is intact
        rd(8'h44, v); check("R4 empty marker", v, 32'hFFFF_FFFF);
        rd(8'h44, v); check("R4 empty marker again", v, 32'hFFFF_FFFF);

        // R8: mask writable bits
        wr(8'h34, 32'hFFFF_FFFF);
        rd(8'h34, v); check("R8 mask writable bits", v, 32'h0000_0309);
        wr(8'h34, 32'h0000_0000);

        // R3 / R7 / R9: context reply, status and interrupt
        complete(1'b0, 31'h0000_CAFE);
        @(negedge clk);
        check("R9 irq after reply", {31'b0, irq}, 1);
        rd(8'h30, v); check("R7 status set", v, 32'h8);
        wr(8'h30, 32'h1);
        check("R7 cleared by ack", {31'b0, irq}, 0);
        @(negedge clk);
        check("R7 reasserted while pending", {31'b0, irq}, 1);
        wr(8'h34, 32'h8);
        check("R9 masked irq", {31'b0, irq}, 0);
        wr(8'h34, 32'h0);
        rd(8'h44, v); check("R3 context reply", v, ctx_reply(31'h0000_CAFE));
        rd(8'h44, v); check("R4 drained marker", v, 32'hFFFF_FFFF);
        wr(8'h30, 32'h1);
        @(negedge clk); @(negedge clk);
        check("R7 no reassert when empty", {31'b0, irq}, 0);

        // R5: fault completion stalls without a free frame
        @(negedge clk);
        cpl_valid = 1; cpl_fault = 1; cpl_context = 31'h1;
        repeat (3) begin
            #1 check("R5 stall without frame", {31'b0, cpl_ready}, 0);
            @(negedge clk);
        end
        wr(8'h44, 32'h0012_3400);   // R6: free frame donated
        #1 check("R5 accepted after frame", {31'b0, cpl_ready}, 1);
        @(posedge clk);
        @(negedge clk) cpl_valid = 0;
        rd(8'h44, v); check("R5 address reply", v, frame_reply(32'h0012_3400));

        // R6: two frames consumed in order
        wr(8'h44, 32'h0000_1000);
        wr(8'h44, 32'h0000_2002);
        complete(1'b1, 31'h0);
        complete(1'b1, 31'h0);
        rd(8'h44, v); check("R6 first frame", v, frame_reply(32'h0000_1000));
        rd(8'h44, v); check("R6 second frame", v, frame_reply(32'h0000_2002));

        // R10: reply FIFO full blocks completions
        for (int i = 0; i < 8; i++) complete(1'b0, 31'(i + 100));
        @(negedge clk);
        cpl_valid = 1; cpl_fault = 0; cpl_context = 31'h55;
        #1 check("R10 full blocks", {31'b0, cpl_ready}, 0);
        @(negedge clk) cpl_valid = 0;
        for (int i = 0; i < 8; i++) begin
            rd(8'h44, v); check("R10 drain order", v, ctx_reply(31'(i + 100)));
        end

        // R1 / R2: request FIFO order and overflow
        for (int i = 0; i < 9; i++) wr(8'h40, 32'hA000_0000 + 32'(i));
        check("R2 overflow set", {31'b0, req_overflow}, 1);
        for (int i = 0; i < 8; i++) begin
            take_req(v); check("R1 request order", v, 32'hA000_0000 + 32'(i));
        end
        check("R1 request empty", {31'b0, req_valid}, 0);
        check("R2 overflow sticky", {31'b0, req_overflow}, 1);

        // Random mix of context completions and reply reads
        for (int i = 0; i < 300; i++) begin
            logic [30:0] c;
            if (($urandom(seed) % 2) == 0 && model_q.size() < 8) begin
                seed = seed + 1;
                c = 31'($urandom(seed));
                complete(1'b0, c);
                model_q.push_back(ctx_reply(c));
            end else begin
                rd(8'h44, v);
                if (model_q.size() == 0) check("R4 random empty", v, 32'hFFFF_FFFF);
                else check("R3 random reply", v, model_q.pop_front());
            end
            seed = seed + 7;
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule